// File: doc/BRIEF.md
# A20 Gate Output-Port Controller

This block is the slice of a legacy keyboard controller that owns the A20 address gate. A host reaches it over an 8-bit I/O interface with two ports. The command/status port sits at I/O address 0x64 and is chosen with `port_sel = 1`. The data port sits at 0x60 and is chosen with `port_sel = 0`. A write strobe and a read strobe complete the interface. Software enables or masks address line 20 in two steps:

1. It writes the output-port write command to the command port.
2. It writes the new output-port value to the data port.

Bit 1 of the stored byte drives the gate.

The real controller was slow, and the block models that. Every write it accepts makes it busy for a fixed, parameterised number of clock cycles. Software is expected to poll the status byte until the busy flag clears before it writes again. Any write that arrives while the block is busy is dropped and leaves no trace.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset `a20_gate` is 0, `outport_dbg` equals the reset value 0xDD, and the status byte reads 0x00.
- R2: Writing 0xD1 to the command port (`port_sel = 1`) and then writing a byte to the data port (`port_sel = 0`) stores that byte, and `outport_dbg` shows it on the cycle after the data write.
- R3: `a20_gate` follows bit 1 of the stored byte. A data byte of 0xDF drives it to 1, and a data byte of 0xDD drives it to 0.
- R4: With `rd_en = 1` and `port_sel = 1`, `rd_data` returns the status byte, which has bit 1 set while busy and every other bit 0. With `rd_en = 0` or `port_sel = 0`, `rd_data` is 0x00.
- R5: Each accepted write keeps the busy bit set for exactly `BUSY_CYCLES` consecutive clock cycles (default 16), starting on the cycle after the write.
- R6: A write to either port while busy is ignored. It does not alter the stored byte, it does not cancel or create an armed command, and it does not extend the busy period.
- R7: A data-port write that is not preceded by 0xD1 leaves the stored byte unchanged.
- R8: Any command byte other than 0xD1 written after 0xD1 disarms the sequence, so the next data write leaves the stored byte unchanged.
- R9: One 0xD1 command arms exactly one data write. A second data write after the stored byte has been loaded has no effect.
- R10: All eight data bits are stored and visible on `outport_dbg`, while only bit 1 reaches `a20_gate` (for example, 0xA7 gives gate 1 and 0x58 gives gate 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | 1 selects the command/status port (0x64), 0 selects the data port (0x60) |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Byte being written |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Status byte on command-port reads, otherwise 0x00 |
| a20_gate | output | 1 | A20 gate enable |
| outport_dbg | output | 8 | Current output-port register contents |

## Verification
The bench aims at the sequencing corners:

- **Data write with no command.** A design that loads on any data write would change the gate here.
- **Command then a non-0xD1 command.** A design that keeps the armed state would load the following data byte.
- **Second data byte after a load.** A design that stays armed would accept it.

It also issues a write one cycle into a busy period. A design that ignores the busy flag, or that restarts the timer on dropped writes, would either change the stored byte or stretch the busy count past the expected remainder of 15. The busy length is measured through the status port after every accepted write, so an off-by-one in the timer shows up as 15 or 17.

// File: rtl/a20_pkg.sv
package a20_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // port select encoding at the host interface
   typedef enum logic {
      PORT_DATA = 1'b0,
      PORT_CMD  = 1'b1
   } port_e;

   // command sequencer state
   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_e;
endpackage

// File: rtl/a20_busy_timer.sv
module a20_busy_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (CYCLES == 0) begin : g_no_wait
         logic unused_start;
         assign unused_start = start;
         assign busy = 1'b0;
      end else begin : g_counter
         localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
         localparam logic [CW-1:0] LOAD = CW'(CYCLES);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (start)
               cnt_q <= LOAD;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign busy = (cnt_q != '0);

         // R6: the top must never start the timer while it is running
         p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> !busy);
         // R5: busy is raised on the cycle after an accepted write
         p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
         // R5: the last counted cycle is followed by idle
         p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CW'(1)) |=> !busy);
      end
   endgenerate
endmodule

// File: rtl/a20_cmd_seq.sv
module a20_cmd_seq
   import a20_pkg::*;
#(
   parameter byte_t CMD_WR_OUT = 8'hD1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  accept,
   input  port_e sel,
   input  byte_t din,
   output logic  load
);
   seq_e state_q;

   assign load = accept && (sel == PORT_DATA) && (state_q == SEQ_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= SEQ_IDLE;
      else if (accept)
         state_q <= ((sel == PORT_CMD) && (din == CMD_WR_OUT)) ? SEQ_ARMED : SEQ_IDLE;
   end

   // R9: a load consumes the armed state
   p_one_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (state_q == SEQ_IDLE));
   // R6: without an accepted write the sequencer state holds
   p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(state_q));
endmodule

// File: rtl/a20_outport.sv
module a20_outport
   import a20_pkg::*;
#(
   parameter byte_t       RST_VAL  = 8'hDD,
   parameter int unsigned GATE_BIT = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  byte_t din,
   output byte_t q,
   output logic  gate
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (load)
         q <= din;
   end

   assign gate = q[GATE_BIT];

   // R7: the register changes only on a load
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
   // R2: a load takes the presented byte
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(din)));
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
   import a20_pkg::*;
#(
   parameter int unsigned BUSY_CYCLES = 16,
   parameter byte_t       CMD_WR_OUT  = 8'hD1,
   parameter byte_t       OUTPORT_RST = 8'hDD,
   parameter int unsigned GATE_BIT    = 1,
   parameter int unsigned BUSY_BIT    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       port_sel,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       a20_gate,
   output logic [7:0] outport_dbg
);
   generate
      if (GATE_BIT >= BYTE_W) begin : g_bad_gate
         $error("GATE_BIT out of range");
      end
      if (BUSY_BIT >= BYTE_W) begin : g_bad_busy
         $error("BUSY_BIT out of range");
      end
      if (OUTPORT_RST[GATE_BIT % BYTE_W]) begin : g_bad_rst
         $error("reset value must leave the gate disabled");
      end
   endgenerate

   logic  busy;
   logic  accept;
   logic  load;
   port_e sel;
   byte_t status;

   assign sel    = port_e'(port_sel);
   assign accept = wr_en && !busy;

   a20_busy_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy)
   );

   a20_cmd_seq #(.CMD_WR_OUT(CMD_WR_OUT)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .sel    (sel),
      .din    (wr_data),
      .load   (load)
   );

   a20_outport #(.RST_VAL(OUTPORT_RST), .GATE_BIT(GATE_BIT)) i_port (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .din   (wr_data),
      .q     (outport_dbg),
      .gate  (a20_gate)
   );

   always_comb begin
      status           = '0;
      status[BUSY_BIT] = busy;
   end

   assign rd_data = (rd_en && (sel == PORT_CMD)) ? status : '0;

   // R6: a write arriving while busy leaves the output port untouched
   p_ignored_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(outport_dbg));
   // R3: the gate moves only when the stored byte moves
   p_gate_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(a20_gate) |-> !$stable(outport_dbg));
endmodule

// File: tb/test_a20_gate_ctrl.sv
module test_a20_gate_ctrl;
   localparam int BUSY = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       a20_gate;
   logic [7:0] outport_dbg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   a20_gate_ctrl #(.BUSY_CYCLES(BUSY)) i_a20_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .a20_gate(a20_gate), .outport_dbg(outport_dbg)
   );

   // vector: {port_sel, data, expected dbg, expected gate}
   localparam int NV = 13;
   localparam logic [17:0] VEC [NV] = '{
      {1'b1, 8'hD1, 8'hDD, 1'b0},   // R2 arm
      {1'b0, 8'hDF, 8'hDF, 1'b1},   // R2 R3 enable
      {1'b0, 8'hDD, 8'hDF, 1'b1},   // R7 unarmed data
      {1'b1, 8'hD1, 8'hDF, 1'b1},
      {1'b0, 8'hDD, 8'hDD, 1'b0},   // R3 disable
      {1'b1, 8'hD1, 8'hDD, 1'b0},
      {1'b0, 8'hA7, 8'hA7, 1'b1},   // R10
      {1'b1, 8'hD1, 8'hA7, 1'b1},
      {1'b1, 8'hAD, 8'hA7, 1'b1},   // R8 other command
      {1'b0, 8'h00, 8'hA7, 1'b1},   // R8 data not loaded
      {1'b1, 8'hD1, 8'hA7, 1'b1},
      {1'b0, 8'h58, 8'h58, 1'b0},   // R10
      {1'b0, 8'hFF, 8'h58, 1'b0}    // R9 second data byte
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called just after a negedge; returns consecutive busy samples
   task automatic busy_len(output int n);
      n = 0;
      port_sel = 1'b1;
      rd_en = 1'b1;
      #1;
      while (rd_data[1] && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
      rd_en = 1'b0;
   endtask

   // called just after a negedge; result is visible after return
   task automatic write_byte(input logic sel, input logic [7:0] d);
      port_sel = sel;
      wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 gate", a20_gate, 0);
      check("R1 dbg", outport_dbg, 8'hDD);
      port_sel = 1'b1;
      rd_en = 1'b1;
      #1;
      check("R1 status", rd_data, 8'h00);
      rd_en = 1'b0;
      #1;
      check("R4 no strobe", rd_data, 8'h00);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         write_byte(VEC[i][17], VEC[i][16:9]);
         check("R2/R3/R7/R8/R9/R10 dbg", outport_dbg, VEC[i][8:1]);
         check("R3 gate", a20_gate, VEC[i][0]);
         port_sel = 1'b0;
         rd_en = 1'b1;
         #1;
         check("R4 data-port read", rd_data, 8'h00);
         port_sel = 1'b1;
         #1;
         check("R4 status busy", rd_data, 8'h02);
         rd_en = 1'b0;
         busy_len(n);
         check("R5 busy length", n - 1, BUSY - 1);
      end

      // R6: a write one cycle into a busy period is dropped
      @(negedge clk);
      write_byte(1'b1, 8'hD1);
      write_byte(1'b0, 8'hDF);
      check("R6 dbg after ignored write", outport_dbg, 8'h58);
      @(negedge clk);
      #1;
      busy_len(n);
      check("R6 busy not extended", n, BUSY - 2);
      @(negedge clk);
      check("R6 still idle", rd_data, 8'h00);
      write_byte(1'b0, 8'h02);
      check("R6 arm survived dbg", outport_dbg, 8'h02);
      check("R6 arm survived gate", a20_gate, 1);
      busy_len(n);

      // R1 reset again restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 gate after re-reset", a20_gate, 0);
      check("R1 dbg after re-reset", outport_dbg, 8'hDD);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule